// File: doc/BRIEF.md
# Error Report Header Serializer

This block sits on the application side of a PCI Express endpoint or root port and forwards one error report at a time to the hard core. The requester presents the whole report in parallel with a single-cycle request strobe. The report consists of a 14-bit error-type vector, a 128-bit TLP header, a 32-bit TLP prefix and a 3-bit function number. The block passes it to the core over a narrow link. That link has a one-cycle valid strobe, a 32-bit header bus and a ready input that the core lowers while it is still handling an earlier message.

A report with at least one error bit set is kept in a one-entry holding slot. The transfer starts only when the block is idle and the core's ready input is high. The valid strobe carries the error vector, the function number and the first header word together. The remaining three header words and the prefix follow in the next four cycles with valid low. The core counts these beats itself. Once a transfer starts it always runs to the end. A done pulse marks the cycle after the last beat. A request whose error vector is all zero is refused with a reject pulse.

Top module: `err_hdr_serializer`

## Requirements
- R1: While reset is held and in the first cycle after it, err_valid, done, reject and busy are low and err_hdr, err_info and err_fn are zero.
- R2: err_valid is high for exactly one cycle per transfer. A transfer starts only at a clock edge where core_ready is high; while core_ready stays low, a held request is not issued.
- R3: The cycle with err_valid high and the four cycles after it carry, on err_hdr, header bits [31:0], [63:32], [95:64], [127:96] and then the 32-bit prefix, in that order.
- R4: err_info and err_fn carry the request's error vector and function number in the err_valid cycle and are zero in every other cycle.
- R5: Once started, all five beats go out on consecutive cycles even if core_ready drops during the transfer.
- R6: Between the last beat of one transfer and the err_valid of the next there is at least one idle cycle. A request that arrives mid-transfer is held and issued with err_valid exactly two cycles after the last beat of the current transfer.
- R7: done is high for exactly one cycle, the cycle after the fifth beat.
- R8: A request whose error vector is all zero raises reject for one cycle, in the cycle after the request, and starts no transfer.
- R9: A request that arrives while the holding slot is full and is not being emptied in that cycle is dropped and never transmitted.
- R10: err_hdr is zero whenever no transfer is in progress.
- R11: busy is high while a transfer is in progress or a request is held, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe from the requester |
| req_info | input | 14 | Error-type vector (bit 0 malformed TLP … bit 13 ECRC check failed) |
| req_fn | input | 3 | Function number of the reporting function |
| req_hdr | input | 128 | TLP header to log |
| req_prefix | input | 32 | TLP prefix to log |
| busy | output | 1 | Transfer in progress or request held |
| done | output | 1 | One-cycle pulse after the fifth beat |
| reject | output | 1 | One-cycle pulse for an all-zero error vector |
| core_ready | input | 1 | Core can accept a new report |
| err_valid | output | 1 | One-cycle strobe marking the first beat |
| err_info | output | 14 | Error-type vector, valid with err_valid |
| err_fn | output | 3 | Function number, valid with err_valid |
| err_hdr | output | 32 | Serialized header and prefix beats |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that req_valid, req_info and core_ready are driven to known values at every sampled edge, because the reject and start checks look back one cycle at those inputs. The bench changes all inputs on the falling edge only and holds the request strobe for exactly one cycle. It releases reset before it issues any request, so every look-back window falls after reset.

// File: rtl/err_ser_pkg.sv
package err_ser_pkg;
  localparam int ERR_INFO_W  = 14;
  localparam int ERR_FN_W    = 3;
  localparam int ERR_BEAT_W  = 32;
  localparam int ERR_HDR_W   = 128;

  // number of beats on the narrow bus: header slices plus one prefix beat
  function automatic int beats_for(input int hdr_w, input int beat_w);
    return hdr_w / beat_w + 1;
  endfunction

  // a report is meaningful only if some error bit is set
  function automatic logic info_nonzero(input logic [ERR_INFO_W-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/err_req_slot.sv
module err_req_slot #(
  parameter int INFO_W = err_ser_pkg::ERR_INFO_W,
  parameter int FN_W   = err_ser_pkg::ERR_FN_W,
  parameter int HDR_W  = err_ser_pkg::ERR_HDR_W,
  parameter int BEAT_W = err_ser_pkg::ERR_BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [INFO_W-1:0] req_info,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [BEAT_W-1:0] req_prefix,
  input  logic              take,
  output logic              pend_vld,
  output logic [INFO_W-1:0] pend_info,
  output logic [FN_W-1:0]   pend_fn,
  output logic [HDR_W-1:0]  pend_hdr,
  output logic [BEAT_W-1:0] pend_prefix,
  output logic              reject
);
  logic good_req;
  logic accept;

  assign good_req = req_valid && err_ser_pkg::info_nonzero(req_info);
  // slot frees in the same cycle it is taken, so a new report may enter then
  assign accept   = good_req && (!pend_vld || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld    <= 1'b0;
      reject      <= 1'b0;
      pend_info   <= '0;
      pend_fn     <= '0;
      pend_hdr    <= '0;
      pend_prefix <= '0;
    end else begin
      reject <= req_valid && !err_ser_pkg::info_nonzero(req_info);
      if (accept) begin
        pend_vld    <= 1'b1;
        pend_info   <= req_info;
        pend_fn     <= req_fn;
        pend_hdr    <= req_hdr;
        pend_prefix <= req_prefix;
      end else if (take) begin
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/err_beat_seq.sv
module err_beat_seq #(
  parameter int NBEATS = 5,
  localparam int CNT_W = $clog2(NBEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  output logic             launch,
  output logic             xfer_on,
  output logic [CNT_W-1:0] beat_idx,
  output logic             last_beat,
  output logic             done
);
  assign launch    = start_ok && !xfer_on;
  assign last_beat = xfer_on && (beat_idx == CNT_W'(NBEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_on  <= 1'b0;
      beat_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        xfer_on  <= 1'b1;
        beat_idx <= '0;
      end else if (xfer_on) begin
        if (last_beat) begin
          xfer_on  <= 1'b0;
          beat_idx <= '0;
          done     <= 1'b1;
        end else begin
          beat_idx <= beat_idx + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/err_beat_mux.sv
module err_beat_mux #(
  parameter int INFO_W = err_ser_pkg::ERR_INFO_W,
  parameter int FN_W   = err_ser_pkg::ERR_FN_W,
  parameter int HDR_W  = err_ser_pkg::ERR_HDR_W,
  parameter int BEAT_W = err_ser_pkg::ERR_BEAT_W,
  parameter int NBEATS = 5,
  localparam int CNT_W = $clog2(NBEATS),
  localparam int HDR_BEATS = HDR_W / BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [INFO_W-1:0] pend_info,
  input  logic [FN_W-1:0]   pend_fn,
  input  logic [HDR_W-1:0]  pend_hdr,
  input  logic [BEAT_W-1:0] pend_prefix,
  input  logic              xfer_on,
  input  logic [CNT_W-1:0]  beat_idx,
  output logic              err_valid,
  output logic [INFO_W-1:0] err_info,
  output logic [FN_W-1:0]   err_fn,
  output logic [BEAT_W-1:0] err_hdr
);
  logic [INFO_W-1:0] cur_info;
  logic [FN_W-1:0]   cur_fn;
  logic [HDR_W-1:0]  cur_hdr;
  logic [BEAT_W-1:0] cur_prefix;

  // header slices in ascending order, prefix after the last slice
  function automatic logic [BEAT_W-1:0] pick_beat(
    input logic [HDR_W-1:0]  h,
    input logic [BEAT_W-1:0] p,
    input logic [CNT_W-1:0]  i
  );
    logic [BEAT_W-1:0] w;
    w = p;
    for (int k = 0; k < HDR_BEATS; k++)
      if (i == CNT_W'(k)) w = h[k*BEAT_W +: BEAT_W];
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_info   <= '0;
      cur_fn     <= '0;
      cur_hdr    <= '0;
      cur_prefix <= '0;
    end else if (launch) begin
      cur_info   <= pend_info;
      cur_fn     <= pend_fn;
      cur_hdr    <= pend_hdr;
      cur_prefix <= pend_prefix;
    end
  end

  assign err_valid = xfer_on && (beat_idx == '0);
  assign err_info  = err_valid ? cur_info : '0;
  assign err_fn    = err_valid ? cur_fn : '0;
  assign err_hdr   = xfer_on ? pick_beat(cur_hdr, cur_prefix, beat_idx) : '0;
endmodule

// File: rtl/err_hdr_serializer.sv
module err_hdr_serializer #(
  parameter int INFO_W = err_ser_pkg::ERR_INFO_W,
  parameter int FN_W   = err_ser_pkg::ERR_FN_W,
  parameter int HDR_W  = err_ser_pkg::ERR_HDR_W,
  parameter int BEAT_W = err_ser_pkg::ERR_BEAT_W,
  localparam int NBEATS = err_ser_pkg::beats_for(HDR_W, BEAT_W),
  localparam int CNT_W  = $clog2(NBEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [INFO_W-1:0] req_info,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [BEAT_W-1:0] req_prefix,
  output logic              busy,
  output logic              done,
  output logic              reject,
  input  logic              core_ready,
  output logic              err_valid,
  output logic [INFO_W-1:0] err_info,
  output logic [FN_W-1:0]   err_fn,
  output logic [BEAT_W-1:0] err_hdr
);
  // named internal events, visible to the bound checker
  logic              pend_vld;
  logic [INFO_W-1:0] pend_info;
  logic [FN_W-1:0]   pend_fn;
  logic [HDR_W-1:0]  pend_hdr;
  logic [BEAT_W-1:0] pend_prefix;
  logic              launch;
  logic              xfer_on;
  logic [CNT_W-1:0]  beat_idx;
  logic              last_beat;

  err_req_slot #(.INFO_W(INFO_W), .FN_W(FN_W), .HDR_W(HDR_W), .BEAT_W(BEAT_W)) u_slot (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_info(req_info),
    .req_fn(req_fn), .req_hdr(req_hdr), .req_prefix(req_prefix), .take(launch),
    .pend_vld(pend_vld), .pend_info(pend_info), .pend_fn(pend_fn),
    .pend_hdr(pend_hdr), .pend_prefix(pend_prefix), .reject(reject)
  );

  err_beat_seq #(.NBEATS(NBEATS)) u_seq (
    .clk(clk), .rst(rst), .start_ok(pend_vld && core_ready), .launch(launch),
    .xfer_on(xfer_on), .beat_idx(beat_idx), .last_beat(last_beat), .done(done)
  );

  err_beat_mux #(.INFO_W(INFO_W), .FN_W(FN_W), .HDR_W(HDR_W), .BEAT_W(BEAT_W),
                 .NBEATS(NBEATS)) u_mux (
    .clk(clk), .rst(rst), .launch(launch), .pend_info(pend_info),
    .pend_fn(pend_fn), .pend_hdr(pend_hdr), .pend_prefix(pend_prefix),
    .xfer_on(xfer_on), .beat_idx(beat_idx), .err_valid(err_valid),
    .err_info(err_info), .err_fn(err_fn), .err_hdr(err_hdr)
  );

  assign busy = xfer_on || pend_vld;
endmodule

// File: rtl/err_ser_chk.sv
module err_ser_chk #(
  parameter int INFO_W = 14,
  parameter int FN_W   = 3,
  parameter int BEAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [INFO_W-1:0] req_info,
  input logic              core_ready,
  input logic              err_valid,
  input logic [INFO_W-1:0] err_info,
  input logic [FN_W-1:0]   err_fn,
  input logic [BEAT_W-1:0] err_hdr,
  input logic              done,
  input logic              reject,
  input logic              busy,
  input logic              xfer_on,
  input logic              last_beat
);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);
  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_valid) |-> $past(core_ready));
  // R4
  idle_info_chk: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> (err_info == '0 && err_fn == '0));
  // R5
  no_break_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_on && !last_beat) |=> xfer_on);
  // R6
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !err_valid);
  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> done);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_info == '0) |=> reject);
  // R10
  idle_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_on |-> err_hdr == '0);
  // R11
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_on |-> busy);
endmodule

bind err_hdr_serializer err_ser_chk #(.INFO_W(INFO_W), .FN_W(FN_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/err_hdr_serializer_test.sv
module err_hdr_serializer_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [13:0]  req_info = '0;
  logic [2:0]   req_fn = '0;
  logic [127:0] req_hdr = '0;
  logic [31:0]  req_prefix = '0;
  logic         busy, done, reject;
  logic         core_ready = 1'b1;
  logic         err_valid;
  logic [13:0]  err_info;
  logic [2:0]   err_fn;
  logic [31:0]  err_hdr;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  err_hdr_serializer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_info(req_info),
    .req_fn(req_fn), .req_hdr(req_hdr), .req_prefix(req_prefix),
    .busy(busy), .done(done), .reject(reject), .core_ready(core_ready),
    .err_valid(err_valid), .err_info(err_info), .err_fn(err_fn), .err_hdr(err_hdr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // beat k of a report built from a seed; k = 4 is the prefix
  function automatic logic [31:0] mk_word(input logic [7:0] seed, input int k);
    return {seed, 8'(k), 8'h5A, seed ^ 8'(k * 37)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // called at a falling edge; returns one falling edge later
  task automatic send_req(input logic [13:0] info, input logic [2:0] fn,
                          input logic [7:0] seed);
    req_valid  = 1'b1;
    req_info   = info;
    req_fn     = fn;
    req_hdr    = {mk_word(seed, 3), mk_word(seed, 2), mk_word(seed, 1), mk_word(seed, 0)};
    req_prefix = mk_word(seed, 4);
    @(negedge clk);
    req_valid  = 1'b0;
    req_info   = '0;
  endtask

  // waits for err_valid, checks the five beats, ends on the done cycle
  task automatic expect_xfer(input logic [13:0] info, input logic [2:0] fn,
                             input logic [7:0] seed, input int exp_wait,
                             input bit drop_ready);
    int n = 0;
    while (!err_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(err_valid, "R2 valid seen", 64'(err_valid), 64'd1);
    if (exp_wait >= 0) check(n == exp_wait, "R6 start spacing", 64'(n), 64'(exp_wait));
    check(err_info == info, "R4 info in valid cycle", 64'(err_info), 64'(info));
    check(err_fn == fn, "R4 fn in valid cycle", 64'(err_fn), 64'(fn));
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin
        @(negedge clk);
        check(!err_valid, "R2 valid low on later beat", 64'(err_valid), 64'd0);
        check(err_info == '0 && err_fn == '0, "R4 info zero off valid",
              64'({err_info, err_fn}), 64'd0);
        check(!done, "R7 done low during beats", 64'(done), 64'd0);
      end
      if (k == 1 && drop_ready) core_ready = 1'b0;
      check(err_hdr == mk_word(seed, k), (k == 4) ? "R3 prefix beat" : "R3 header beat",
            64'(err_hdr), 64'(mk_word(seed, k)));
    end
    @(negedge clk);
    check(done, "R7 done after fifth beat", 64'(done), 64'd1);
    check(err_hdr == '0, "R10 header bus idle zero", 64'(err_hdr), 64'd0);
    check(!err_valid, "R6 idle cycle after last beat", 64'(err_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!err_valid && !done && !reject && !busy, "R1 reset outputs low",
          64'({err_valid, done, reject, busy}), 64'd0);
    check(err_hdr == '0 && err_info == '0 && err_fn == '0, "R1 reset buses zero",
          64'(err_hdr), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!err_valid && !busy && err_hdr == '0, "R1 first cycle after reset",
          64'({err_valid, busy}), 64'd0);

    // sweep every single error bit, then mixed vectors
    for (int i = 0; i < 14; i++) begin
      send_req(14'(1 << i), 3'(i % 8), 8'(i + 1));
      expect_xfer(14'(1 << i), 3'(i % 8), 8'(i + 1), 1, 1'b0);
      check(!busy, "R11 busy low when idle", 64'(busy), 64'd0);
      core_ready = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      logic [13:0] v;
      v = 14'(14'h3FFF >> (i * 3)) ^ 14'(i);
      send_req(v, 3'(7 - i), 8'(8'h40 + i));
      expect_xfer(v, 3'(7 - i), 8'(8'h40 + i), 1, 1'b0);
    end

    // R5: ready falls during the transfer, beats continue
    send_req(14'h0011, 3'd5, 8'h77);
    expect_xfer(14'h0011, 3'd5, 8'h77, 1, 1'b1);
    core_ready = 1'b1;
    @(negedge clk);

    // R2: ready low holds the request
    core_ready = 1'b0;
    send_req(14'h2001, 3'd2, 8'h91);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!err_valid, "R2 no start while ready low", 64'(err_valid), 64'd0);
      check(busy, "R11 busy while held", 64'(busy), 64'd1);
    end
    core_ready = 1'b1;
    expect_xfer(14'h2001, 3'd2, 8'h91, 1, 1'b0);

    // R6: request arriving mid-transfer is held and sent after
    send_req(14'h0100, 3'd1, 8'hA0);
    fork
      expect_xfer(14'h0100, 3'd1, 8'hA0, 1, 1'b0);
      begin
        repeat (2) @(negedge clk);
        send_req(14'h0402, 3'd6, 8'hB3);
      end
    join
    check(busy, "R11 busy with held request", 64'(busy), 64'd1);
    expect_xfer(14'h0402, 3'd6, 8'hB3, 1, 1'b0);

    // R9: second request while slot full is dropped
    core_ready = 1'b0;
    send_req(14'h0020, 3'd3, 8'hC1);
    send_req(14'h0040, 3'd4, 8'hC2);
    core_ready = 1'b1;
    expect_xfer(14'h0020, 3'd3, 8'hC1, 1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!err_valid, "R9 dropped request not sent", 64'(err_valid), 64'd0);
    end
    check(!busy, "R9 nothing held after drop", 64'(busy), 64'd0);

    // R8: all-zero vector is rejected
    req_valid = 1'b1;
    req_info  = '0;
    req_fn    = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    check(reject, "R8 reject pulse", 64'(reject), 64'd1);
    check(!busy, "R8 rejected request not held", 64'(busy), 64'd0);
    @(negedge clk);
    check(!reject, "R8 reject one cycle", 64'(reject), 64'd0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!err_valid, "R8 no transfer after reject", 64'(err_valid), 64'd0);
    end

    finish_run();
  end
endmodule